// File: doc/BRIEF.md
# Bridge System Error Reporter

This block gathers error events from both sides of a transparent bus-to-bus bridge. It decides when to pulse the active-low system error output on the primary side. The protocol engines feed it one-cycle strobes for the following:
- data parity errors, each tagged with transaction kind, direction and the bus or buses that detected it;
- target aborts and master aborts on posted writes;
- start and retry terminations of posted writes;
- the sampled secondary-side system error input.

The block holds its own enable bits, which are loaded by two write strobes. It also holds two sticky status flags that software clears by writing one. A retry counter sits beside them and declares a posted write discarded once it has been retried 2^RETRY_W times. The discard is reported to the engines on `pw_discard` and is itself a system error condition.

Every event is registered, so the output goes low in the clock after the cycle in which the cause was presented. All causes seen in one cycle produce a single low clock.

Top module: `bridge_serr_ctl`

## Requirements
- R1: `pri_serr_n` is driven low only when the system-error enable bit is set. That bit is held in the command byte and is loaded from `cmd_wdata[0]` when `cmd_wr` is high. When the bit is clear, no event drives the output low.
- R2: In every clock where `pri_serr_n` is low, `sig_serr_sts` reads one from that same clock onward.
- R3: If `sec_serr_n` is low while the forward-enable bit is set (`bctl_wdata[1]` on a `bctl_wr`), the following clock shows `rcv_serr_sts` set. `pri_serr_n` is also low in that clock if R1 allows it. When forward-enable is clear, the input has no effect.
- R4: A parity error whose `perr_type` is read (0) or delayed write (2) never lowers `pri_serr_n`, whatever the response bits hold.
- R5: A posted write (`perr_type`=1) lowers the output under two conditions. Downstream (`perr_upstream`=0), it must be flagged by `perr_on_sec` alone. Upstream (`perr_upstream`=1), it must be flagged by `perr_on_pri` alone. If both buses or neither bus flagged it, there is no effect.
- R6: The posted-write parity case also needs two response bits set: the command one (`cmd_wdata[1]`) and the bridge-control one (`bctl_wdata[0]`).
- R7: A `pw_tabort` or `pw_mabort` strobe lowers the output for one clock.
- R8: After `pw_start`, the output goes low on the 2^RETRY_W-th `pw_retry` strobe. That is the clock after the strobe. `pw_discard` pulses high in the same clock. Earlier retries cause neither.
- R9: `pw_start` reloads the retry count to zero. If a retry arrives in the same cycle, it counts as the first retry.
- R10: The output is low for exactly one clock for each cycle that holds at least one reportable cause. Several causes in one cycle merge into one low clock.
- R11: A `pri_sts_clr` strobe clears `sig_serr_sts` and a `sec_sts_clr` strobe clears `rcv_serr_sts`. A set in the same cycle wins over the clear.
- R12: After reset, the output is high, `pw_discard` is low, both status flags are zero and every enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Load command enable bits |
| cmd_wdata | input | 2 | bit0 system-error enable, bit1 parity response |
| bctl_wr | input | 1 | Load bridge-control bits |
| bctl_wdata | input | 2 | bit0 parity response, bit1 secondary forward enable |
| pri_sts_clr | input | 1 | Write-one-clear of the signaled flag |
| sec_sts_clr | input | 1 | Write-one-clear of the received flag |
| perr_vld | input | 1 | Data parity error strobe |
| perr_type | input | 2 | 0 read, 1 posted write, 2 delayed write |
| perr_upstream | input | 1 | 1 when the transaction flows upstream |
| perr_on_pri | input | 1 | Error seen on the primary bus |
| perr_on_sec | input | 1 | Error seen on the secondary bus |
| pw_tabort | input | 1 | Target abort on a posted write |
| pw_mabort | input | 1 | Master abort on a posted write |
| pw_start | input | 1 | New posted write begins delivery |
| pw_retry | input | 1 | Posted write got a retry termination |
| sec_serr_n | input | 1 | Secondary system error input, active low |
| pri_serr_n | output | 1 | Primary system error output, active low |
| pw_discard | output | 1 | Posted write dropped after retry exhaustion |
| sig_serr_sts | output | 1 | Sticky signaled-system-error flag |
| rcv_serr_sts | output | 1 | Sticky received-system-error flag |

## Verification
The bench builds the block with RETRY_W=4, so a posted write is discarded after 16 retries instead of about sixteen million. This brings the discard boundary within reach: the bench checks the retry just before it, the exhausting retry itself, and a reload in the middle of a count. The parity case is driven across every kind, direction, detecting bus and response-bit pair, which is 48 combinations. These are followed by cases where both buses flag the error and where the enable bit is off.

// File: rtl/bridge_serr_pkg.sv
package bridge_serr_pkg;

    typedef enum logic [1:0] {
        XFER_READ    = 2'd0,
        XFER_POSTED  = 2'd1,
        XFER_DELAYED = 2'd2
    } xfer_e;

    typedef struct packed {
        logic cmd_serr_en;
        logic cmd_perr_resp;
        logic bctl_perr_resp;
        logic bctl_fwd_en;
        logic sig_serr;
        logic rcv_serr;
        logic serr_pulse;
        logic discard;
    } serr_state_t;

endpackage

// File: rtl/bridge_serr_retry.sv
module bridge_serr_retry #(
    parameter int CNT_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic retry,
    output logic exhausted
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        exhausted = 1'b0;
        if (start) begin
            cnt_d = retry ? CNT_ONE : '0;
        end else if (retry) begin
            cnt_d     = cnt_q + CNT_ONE;
            exhausted = (cnt_q == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bridge_serr_perr.sv
module bridge_serr_perr
    import bridge_serr_pkg::*;
(
    input  logic       vld,
    input  logic [1:0] kind,
    input  logic       upstream,
    input  logic       on_pri,
    input  logic       on_sec,
    input  logic       resp_cmd,
    input  logic       resp_bctl,
    output logic       hit
);
    logic posted;
    logic target_only;

    always_comb begin
        posted      = (kind == XFER_POSTED);
        // target bus flagged it, initiator bus did not
        target_only = upstream ? (on_pri && !on_sec) : (on_sec && !on_pri);
        hit         = vld && posted && target_only && resp_cmd && resp_bctl;
    end
endmodule

// File: rtl/bridge_serr_ctl.sv
module bridge_serr_ctl
    import bridge_serr_pkg::*;
#(
    parameter int RETRY_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [1:0] cmd_wdata,
    input  logic       bctl_wr,
    input  logic [1:0] bctl_wdata,
    input  logic       pri_sts_clr,
    input  logic       sec_sts_clr,
    input  logic       perr_vld,
    input  logic [1:0] perr_type,
    input  logic       perr_upstream,
    input  logic       perr_on_pri,
    input  logic       perr_on_sec,
    input  logic       pw_tabort,
    input  logic       pw_mabort,
    input  logic       pw_start,
    input  logic       pw_retry,
    input  logic       sec_serr_n,
    output logic       pri_serr_n,
    output logic       pw_discard,
    output logic       sig_serr_sts,
    output logic       rcv_serr_sts
);
    serr_state_t st_d, st_q;
    logic perr_hit;
    logic exhausted;
    logic sec_evt;
    logic any_evt;
    logic serr_en_w;
    logic fwd_en_w;

    bridge_serr_perr u_perr (
        .vld       (perr_vld),
        .kind      (perr_type),
        .upstream  (perr_upstream),
        .on_pri    (perr_on_pri),
        .on_sec    (perr_on_sec),
        .resp_cmd  (st_q.cmd_perr_resp),
        .resp_bctl (st_q.bctl_perr_resp),
        .hit       (perr_hit)
    );

    bridge_serr_retry #(.CNT_W(RETRY_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pw_start),
        .retry     (pw_retry),
        .exhausted (exhausted)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_wr) begin
            st_d.cmd_serr_en   = cmd_wdata[0];
            st_d.cmd_perr_resp = cmd_wdata[1];
        end
        if (bctl_wr) begin
            st_d.bctl_perr_resp = bctl_wdata[0];
            st_d.bctl_fwd_en    = bctl_wdata[1];
        end
        sec_evt = !sec_serr_n && st_q.bctl_fwd_en;
        any_evt = perr_hit || pw_tabort || pw_mabort || exhausted || sec_evt;
        st_d.serr_pulse = any_evt && st_q.cmd_serr_en;
        st_d.discard    = exhausted;
        if (pri_sts_clr)     st_d.sig_serr = 1'b0;
        if (st_d.serr_pulse) st_d.sig_serr = 1'b1;
        if (sec_sts_clr)     st_d.rcv_serr = 1'b0;
        if (sec_evt)         st_d.rcv_serr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_serr_n   = !st_q.serr_pulse;
    assign pw_discard   = st_q.discard;
    assign sig_serr_sts = st_q.sig_serr;
    assign rcv_serr_sts = st_q.rcv_serr;
    assign serr_en_w    = st_q.cmd_serr_en;
    assign fwd_en_w     = st_q.bctl_fwd_en;
endmodule

// File: rtl/bridge_serr_chk.sv
module bridge_serr_chk
    import bridge_serr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       serr_n,
    input logic       sig_sts,
    input logic       rcv_sts,
    input logic       discard,
    input logic       serr_en,
    input logic       fwd_en,
    input logic       perr_vld,
    input logic [1:0] perr_type,
    input logic       tabort,
    input logic       mabort,
    input logic       retry,
    input logic       sec_n
);
    // R1
    serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(serr_en));

    // R2
    serr_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> sig_sts);

    // R3
    rcv_needs_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rcv_sts) |-> $past(!sec_n && fwd_en));

    // R4
    nonposted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_vld && perr_type != XFER_POSTED && !tabort && !mabort && !retry && sec_n)
        |=> serr_n);

    // R10
    serr_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(perr_vld || tabort || mabort || retry || !sec_n));

    // R8
    discard_after_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> $past(retry));
endmodule

bind bridge_serr_ctl bridge_serr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .serr_n    (pri_serr_n),
    .sig_sts   (sig_serr_sts),
    .rcv_sts   (rcv_serr_sts),
    .discard   (pw_discard),
    .serr_en   (serr_en_w),
    .fwd_en    (fwd_en_w),
    .perr_vld  (perr_vld),
    .perr_type (perr_type),
    .tabort    (pw_tabort),
    .mabort    (pw_mabort),
    .retry     (pw_retry),
    .sec_n     (sec_serr_n)
);

// File: tb/bridge_serr_ctl_bench.sv
module bridge_serr_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 4;
    localparam int NRETRY = 1 << RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr, bctl_wr, pri_sts_clr, sec_sts_clr;
    logic [1:0] cmd_wdata, bctl_wdata, perr_type;
    logic perr_vld, perr_upstream, perr_on_pri, perr_on_sec;
    logic pw_tabort, pw_mabort, pw_start, pw_retry, sec_serr_n;
    logic pri_serr_n, pw_discard, sig_serr_sts, rcv_serr_sts;

    int checks = 0;
    int errors = 0;
    bit exp_sig = 0;
    bit exp_rcv = 0;

    typedef struct {
        bit    serr_low;
        bit    sig;
        bit    rcv;
        bit    disc;
        string req;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_serr_ctl #(.RETRY_W(RW)) u_bridge_serr_ctl (.*);

    task automatic check4(bit s, bit g, bit r, bit d, exp_t e);
        checks++;
        if (s != e.serr_low || g != e.sig || r != e.rcv || d != e.disc) begin
            errors++;
            $display("FAIL %s: actual serr_low=%0b sig=%0b rcv=%0b disc=%0b expected %0b %0b %0b %0b",
                     e.req, s, g, r, d, e.serr_low, e.sig, e.rcv, e.disc);
        end
    endtask

    // monitor: compares one expectation per clock after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check4(!pri_serr_n, sig_serr_sts, rcv_serr_sts, pw_discard, e);
        end
    end

    task automatic idle_inputs();
        cmd_wr = 0; bctl_wr = 0; cmd_wdata = 0; bctl_wdata = 0;
        pri_sts_clr = 0; sec_sts_clr = 0;
        perr_vld = 0; perr_type = 0; perr_upstream = 0; perr_on_pri = 0; perr_on_sec = 0;
        pw_tabort = 0; pw_mabort = 0; pw_start = 0; pw_retry = 0; sec_serr_n = 1;
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    // driver: pushes the expected result of the current cycle's stimulus
    task automatic expect_item(bit serr, bit rcv_set, bit disc, string req);
        exp_t e;
        if (pri_sts_clr) exp_sig = 0;
        if (serr) exp_sig = 1;
        if (sec_sts_clr) exp_rcv = 0;
        if (rcv_set) exp_rcv = 1;
        e.serr_low = serr; e.sig = exp_sig; e.rcv = exp_rcv; e.disc = disc; e.req = req;
        q.push_back(e);
    endtask

    task automatic cfg(bit serr_en, bit resp_c, bit resp_b, bit fwd);
        begin_cycle();
        cmd_wr = 1; cmd_wdata = {resp_c, serr_en};
        bctl_wr = 1; bctl_wdata = {fwd, resp_b};
    endtask

    task automatic clear_all();
        begin_cycle();
        pri_sts_clr = 1; sec_sts_clr = 1;
        expect_item(0, 0, 0, "R11");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check4(!pri_serr_n, sig_serr_sts, rcv_serr_sts, pw_discard, '{0, 0, 0, 0, "R12"});
        @(negedge clk);
        rst_n = 1;

        // R12 enables clear after reset: an abort does nothing
        begin_cycle(); pw_tabort = 1; expect_item(0, 0, 0, "R12");

        // parity truth table, R4 R5 R6
        for (int t = 0; t < 3; t++)
            for (int dir = 0; dir < 2; dir++)
                for (int bus = 0; bus < 2; bus++)
                    for (int rb = 0; rb < 4; rb++) begin
                        bit hit;
                        string tag;
                        cfg(1, rb[1], rb[0], 0);
                        begin_cycle();
                        perr_vld = 1; perr_type = 2'(t); perr_upstream = dir[0];
                        perr_on_pri = (bus == 0); perr_on_sec = (bus == 1);
                        hit = (t == 1) && (rb == 3) &&
                              ((dir == 0 && bus == 1) || (dir == 1 && bus == 0));
                        tag = (t != 1) ? "R4" : ((rb == 3) ? "R5" : "R6");
                        expect_item(hit, 0, 0, tag);
                    end

        cfg(1, 1, 1, 0);
        // R5 both buses flagged: no report
        begin_cycle(); perr_vld = 1; perr_type = 1; perr_on_pri = 1; perr_on_sec = 1;
        expect_item(0, 0, 0, "R5");
        begin_cycle(); perr_vld = 1; perr_type = 1; perr_upstream = 1; perr_on_pri = 1; perr_on_sec = 1;
        expect_item(0, 0, 0, "R5");

        // R11 clear and set-wins
        clear_all();
        begin_cycle(); pw_mabort = 1; pri_sts_clr = 1; expect_item(1, 0, 0, "R11");
        clear_all();

        // R7 aborts
        begin_cycle(); pw_tabort = 1; expect_item(1, 0, 0, "R7");
        begin_cycle(); expect_item(0, 0, 0, "R10");
        begin_cycle(); pw_mabort = 1; expect_item(1, 0, 0, "R7");

        // R10 merge: three causes in one cycle, then idle
        cfg(1, 1, 1, 1);
        begin_cycle(); pw_tabort = 1; pw_mabort = 1; sec_serr_n = 0; expect_item(1, 1, 0, "R10");
        begin_cycle(); expect_item(0, 0, 0, "R10");
        clear_all();

        // R3 forwarding
        begin_cycle(); sec_serr_n = 0; expect_item(1, 1, 0, "R3");
        clear_all();
        cfg(0, 1, 1, 1);
        begin_cycle(); sec_serr_n = 0; expect_item(0, 1, 0, "R3");
        clear_all();
        cfg(1, 1, 1, 0);
        begin_cycle(); sec_serr_n = 0; expect_item(0, 0, 0, "R3");

        // R1 enable off blocks every cause
        cfg(0, 1, 1, 0);
        begin_cycle(); perr_vld = 1; perr_type = 1; perr_on_sec = 1; pw_tabort = 1; pw_mabort = 1;
        expect_item(0, 0, 0, "R1");

        // R8 discard after NRETRY retries, enable off: discard pulse without report (R1)
        begin_cycle(); pw_start = 1; expect_item(0, 0, 0, "R9");
        for (int i = 1; i < NRETRY; i++) begin
            begin_cycle(); pw_retry = 1; expect_item(0, 0, 0, "R8");
        end
        begin_cycle(); pw_retry = 1; expect_item(0, 0, 1, "R1");

        cfg(1, 1, 1, 0);
        begin_cycle(); pw_start = 1; expect_item(0, 0, 0, "R9");
        for (int i = 1; i < NRETRY; i++) begin
            begin_cycle(); pw_retry = 1; expect_item(0, 0, 0, "R8");
        end
        begin_cycle(); pw_retry = 1; expect_item(1, 0, 1, "R8");
        begin_cycle(); expect_item(0, 0, 0, "R8");

        // R9 reload mid-count, then start with simultaneous retry
        begin_cycle(); pw_start = 1; expect_item(0, 0, 0, "R9");
        for (int i = 0; i < 10; i++) begin
            begin_cycle(); pw_retry = 1; expect_item(0, 0, 0, "R9");
        end
        begin_cycle(); pw_start = 1; pw_retry = 1; expect_item(0, 0, 0, "R9");
        for (int i = 2; i < NRETRY; i++) begin
            begin_cycle(); pw_retry = 1; expect_item(0, 0, 0, "R9");
        end
        begin_cycle(); pw_retry = 1; expect_item(1, 0, 1, "R9");

        // R2 status after report persists
        begin_cycle(); expect_item(0, 0, 0, "R2");

        begin_cycle();
        repeat (2) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule